// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This block identifies the NOR flash on an asynchronous parallel bus after power-up. When the host pulses `start`, the block writes the three-cycle unlock and autoselect sequence. It then waits a set number of clocks and reads the manufacturer code from word offset 0 and the device code from word offset 1. If both are recognised, it reads the same two identifiers through a second address window. A copy there means the bank is only decoded twice, so the bank is reported as absent. The block then writes a read-mode command suited to the detected manufacturer and returns the flash to array reads. Finally it pulses `done` for one clock, with the results on its outputs.

The flash side is a word address, a write-data bus, a read-data bus and three active-low strobes: chip enable, write enable and output enable. Every bus cycle holds its address and data for one clock before the strobe and one clock after it. The strobe itself lasts `PULSE_CLKS` clocks. The host reads four results: a vendor code, a device-known flag, the sector count and the bank size in bytes.

Top module: `nor_id_probe`

## Requirements
- R1: After a synchronous active-low reset, `done`, `vendor`, `dev_known`, `sector_count` and `bank_bytes` are 0, and `flash_ce_n`, `flash_we_n` and `flash_oe_n` are 1.
- R2: A probe starts with exactly three bus writes, in this order, with the data in the low byte: 0xAA to word address BASE+0x555, 0x55 to BASE+0x2AA, then 0x90 to BASE+0x555.
- R3: Every bus cycle drives `flash_ce_n` low for exactly `PULSE_CLKS` clocks. In those clocks, `flash_we_n` is low for a write or `flash_oe_n` is low for a read, and never both. Address and write data are already stable one clock before the strobe, stay stable through it, and stay stable one clock after it.
- R4: At least `WAIT_CLKS` clocks pass between the end of the third command write and the start of the first identifier read.
- R5: Only bits 7:0 of the word read at BASE+0 are used to decide the manufacturer. 0x01 gives `vendor`=1, 0x89 gives `vendor`=2, and any other value gives `vendor`=0, `dev_known`=0, count 0 and size 0. An unknown manufacturer ends the probe with no further bus cycles.
- R6: The full 16-bit word read at BASE+1 is compared with `DEV_ID` (0x0093). If it matches and no mirror is found, the block reports `dev_known`=1, `sector_count`=128 and `bank_bytes`=0x0080_0000.
- R7: If the device word does not match, the block reports `dev_known`=0, `sector_count`=0 and `bank_bytes`=0. The vendor code is still reported. No read of the second window is made, so exactly two reads take place.
- R8: If the device is known, the block reads the manufacturer and device words at (BASE | 0x400000)+0 and +1. If both equal the first window's values (manufacturer compared on bits 7:0), the bank is reported absent: `dev_known`=0, count 0 and size 0.
- R9: When the manufacturer is recognised, the last bus cycle is a write to BASE+0. It writes 0xF0 for `vendor`=1 or 0xFF for `vendor`=2. An unknown manufacturer gets no such write.
- R10: `done` is high for exactly one clock per probe. The result outputs change only at that clock and hold their values afterwards.
- R11: A `start` pulse while a probe is in progress is ignored. It causes no extra bus cycle and no extra `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start a probe (accepted only when idle) |
| done | output | 1 | One-clock pulse when results are valid |
| vendor | output | 2 | 0 unknown, 1 vendor using 0xF0 exit, 2 vendor using 0xFF exit |
| dev_known | output | 1 | Supported device found and not mirrored |
| sector_count | output | SECT_W | Number of uniform sectors (0 if absent) |
| bank_bytes | output | BYTES_W | Bank size in bytes (0 if absent) |
| flash_addr | output | ADDR_W | Flash word address |
| flash_wdata | output | DATA_W | Flash write data |
| flash_rdata | input | DATA_W | Flash read data |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
The bench targets the branches that stop a probe early. With an unknown manufacturer, a faulty design would still read the device word or write a read-mode command. With an unknown device, a faulty design would go on and read the second window. Manufacturer words with a non-zero high byte catch a design that compares the full word, and device words that differ only in the high byte catch a design that compares only the low byte. A mirrored model, once for each vendor, catches a design that skips the alias comparison or picks the wrong exit command. Monitoring strobe width, setup, hold, the wait gap and repeated start pulses catches an engine whose counter is off by one, a wait that is too short, and a sequencer that restarts when it should not.

// File: rtl/nor_probe_pkg.sv
// Shared types for the NOR identification probe.
// Assumes an 8-bit manufacturer code in the low byte of the bus word.
package nor_probe_pkg;

    typedef enum logic [1:0] {
        VND_NONE = 2'd0,
        VND_A    = 2'd1,
        VND_B    = 2'd2
    } vendor_e;

    typedef enum logic [1:0] {
        BC_IDLE,
        BC_SETUP,
        BC_STROBE,
        BC_HOLD
    } bus_st_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_WAIT,
        S_RD_MFR,
        S_RD_DEV,
        S_RD_AMFR,
        S_RD_ADEV,
        S_RST,
        S_DONE
    } seq_st_e;

    // Map a manufacturer byte onto a vendor code.
    function automatic vendor_e vendor_of(input logic [7:0] code,
                                          input logic [7:0] code_a,
                                          input logic [7:0] code_b);
        if (code == code_a)      return VND_A;
        else if (code == code_b) return VND_B;
        else                     return VND_NONE;
    endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
// One asynchronous flash bus cycle per request.
// Phases: one setup clock, PULSE_CLKS strobe clocks, one hold clock.
// ack is high in the hold clock. The request is sampled only when idle, so
// the requester may hold req high until it sees ack.
// Read data is captured on the last strobe clock.
module nor_bus_cycle
    import nor_probe_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int PULSE_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n
);
    localparam int CNT_W = (PULSE_CLKS < 2) ? 1 : $clog2(PULSE_CLKS);

    bus_st_e           st;
    logic [CNT_W-1:0]  cnt;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Step through the setup/strobe/hold phases and latch the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BC_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            case (st)
                BC_IDLE: begin
                    if (req) begin
                        wr_q    <= req_wr;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        st      <= BC_SETUP;
                    end
                end
                BC_SETUP: begin
                    cnt <= CNT_W'(PULSE_CLKS - 1);
                    st  <= BC_STROBE;
                end
                BC_STROBE: begin
                    if (cnt == '0) begin
                        if (!wr_q) rdata <= bus_rdata;
                        st <= BC_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= BC_IDLE;
            endcase
        end
    end

    // Strobes and ack are decoded from the phase.
    always_comb begin
        ce_n = (st != BC_STROBE);
        we_n = !((st == BC_STROBE) && wr_q);
        oe_n = !((st == BC_STROBE) && !wr_q);
        ack  = (st == BC_HOLD);
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;

endmodule

// File: rtl/nor_probe_seq.sv
// Probe sequencer: command writes, settle wait, identifier reads, alias
// reads and the read-mode exit write.
// Assumes the bus engine acks each request in its hold clock.
// done_q is high one clock after the S_DONE state.
module nor_probe_seq
    import nor_probe_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                DATA_W    = 16,
    parameter int                WAIT_CLKS = 10000,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter logic [ADDR_W-1:0] ALIAS_OFS = 'h400000,
    parameter logic [DATA_W-1:0] DEV_ID    = 'h0093,
    parameter logic [7:0]        MFR_A     = 8'h01,
    parameter logic [7:0]        MFR_B     = 8'h89
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] rst_cmd,
    output logic              req,
    output logic              req_wr,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic              fin,
    output logic              done_q,
    output logic [7:0]        mfr_q,
    output logic [DATA_W-1:0] dev_q,
    output logic [7:0]        amfr_q,
    output logic [DATA_W-1:0] adev_q
);
    localparam int WCNT_W = (WAIT_CLKS < 2) ? 1 : $clog2(WAIT_CLKS);
    localparam logic [ADDR_W-1:0] ALIAS_ADDR = BASE_ADDR | ALIAS_OFS;

    seq_st_e           st;
    logic [1:0]        idx;
    logic [WCNT_W-1:0] wcnt;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;

    // Command table for the three autoselect writes.
    always_comb begin
        case (idx)
            2'd0:    begin cmd_addr = BASE_ADDR | ADDR_W'('h555); cmd_data = DATA_W'(8'hAA); end
            2'd1:    begin cmd_addr = BASE_ADDR | ADDR_W'('h2AA); cmd_data = DATA_W'(8'h55); end
            default: begin cmd_addr = BASE_ADDR | ADDR_W'('h555); cmd_data = DATA_W'(8'h90); end
        endcase
    end

    // Advance through the probe and capture identifier words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            idx    <= '0;
            wcnt   <= '0;
            mfr_q  <= '0;
            dev_q  <= '0;
            amfr_q <= '0;
            adev_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (st == S_DONE);
            case (st)
                S_IDLE: begin
                    if (start) begin
                        idx    <= '0;
                        mfr_q  <= '0;
                        dev_q  <= '0;
                        amfr_q <= '0;
                        adev_q <= '0;
                        st     <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (ack) begin
                        if (idx == 2'd2) begin
                            wcnt <= WCNT_W'(WAIT_CLKS - 1);
                            st   <= S_WAIT;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                S_WAIT: begin
                    if (wcnt == '0) st <= S_RD_MFR;
                    else            wcnt <= wcnt - 1'b1;
                end
                S_RD_MFR: begin
                    if (ack) begin
                        mfr_q <= rdata[7:0];
                        st    <= (vendor_of(rdata[7:0], MFR_A, MFR_B) != VND_NONE)
                                 ? S_RD_DEV : S_DONE;
                    end
                end
                S_RD_DEV: begin
                    if (ack) begin
                        dev_q <= rdata;
                        st    <= (rdata == DEV_ID) ? S_RD_AMFR : S_RST;
                    end
                end
                S_RD_AMFR: begin
                    if (ack) begin
                        amfr_q <= rdata[7:0];
                        st     <= S_RD_ADEV;
                    end
                end
                S_RD_ADEV: begin
                    if (ack) begin
                        adev_q <= rdata;
                        st     <= S_RST;
                    end
                end
                S_RST: begin
                    if (ack) st <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Bus request for the current state.
    always_comb begin
        req       = 1'b0;
        req_wr    = 1'b0;
        req_addr  = BASE_ADDR;
        req_wdata = '0;
        case (st)
            S_CMD:     begin req = 1'b1; req_wr = 1'b1; req_addr = cmd_addr; req_wdata = cmd_data; end
            S_RD_MFR:  begin req = 1'b1; req_addr = BASE_ADDR; end
            S_RD_DEV:  begin req = 1'b1; req_addr = BASE_ADDR | ADDR_W'(1); end
            S_RD_AMFR: begin req = 1'b1; req_addr = ALIAS_ADDR; end
            S_RD_ADEV: begin req = 1'b1; req_addr = ALIAS_ADDR | ADDR_W'(1); end
            S_RST:     begin req = 1'b1; req_wr = 1'b1; req_addr = BASE_ADDR; req_wdata = rst_cmd; end
            default:   ;
        endcase
    end

    assign fin = (st == S_DONE);

endmodule

// File: rtl/nor_id_decode.sv
// Turns the captured identifier words into the reported results and the
// vendor-specific read-mode command. Purely combinational.
// Assumes unread words were cleared to zero at the start of the probe.
module nor_id_decode
    import nor_probe_pkg::*;
#(
    parameter int                DATA_W       = 16,
    parameter logic [DATA_W-1:0] DEV_ID       = 'h0093,
    parameter logic [7:0]        MFR_A        = 8'h01,
    parameter logic [7:0]        MFR_B        = 8'h89,
    parameter int                SECTORS      = 128,
    parameter int                SECTOR_BYTES = 65536,
    parameter int                SECT_W       = 8,
    parameter int                BYTES_W      = 32
) (
    input  logic [7:0]         mfr_q,
    input  logic [DATA_W-1:0]  dev_q,
    input  logic [7:0]         amfr_q,
    input  logic [DATA_W-1:0]  adev_q,
    output logic [1:0]         vendor,
    output logic               known,
    output logic [SECT_W-1:0]  sectors,
    output logic [BYTES_W-1:0] bytes,
    output logic [DATA_W-1:0]  rst_cmd
);
    localparam logic [BYTES_W-1:0] BANK_BYTES = BYTES_W'(SECTORS * SECTOR_BYTES);

    vendor_e vnd;
    logic    dev_hit;
    logic    mirrored;

    // Classify the vendor, device and mirror state.
    always_comb begin
        vnd      = vendor_of(mfr_q, MFR_A, MFR_B);
        dev_hit  = (dev_q == DEV_ID);
        mirrored = (amfr_q == mfr_q) && (adev_q == dev_q);
        known    = (vnd != VND_NONE) && dev_hit && !mirrored;
        vendor   = vnd;
        sectors  = known ? SECT_W'(SECTORS) : '0;
        bytes    = known ? BANK_BYTES : '0;
        case (vnd)
            VND_A:   rst_cmd = DATA_W'(8'hF0);
            VND_B:   rst_cmd = DATA_W'(8'hFF);
            default: rst_cmd = '0;
        endcase
    end

endmodule

// File: rtl/nor_id_probe.sv
// Top level of the NOR identification probe: sequencer, bus engine,
// identifier decode and the result registers.
// Assumes a 16-bit or wider bus and one probe per start pulse.
module nor_id_probe
    import nor_probe_pkg::*;
#(
    parameter int                ADDR_W       = 24,
    parameter int                DATA_W       = 16,
    parameter int                PULSE_CLKS   = 4,
    parameter int                WAIT_CLKS    = 10000,
    parameter logic [ADDR_W-1:0] BASE_ADDR    = '0,
    parameter logic [ADDR_W-1:0] ALIAS_OFS    = 'h400000,
    parameter logic [DATA_W-1:0] DEV_ID       = 'h0093,
    parameter logic [7:0]        MFR_A        = 8'h01,
    parameter logic [7:0]        MFR_B        = 8'h89,
    parameter int                SECTORS      = 128,
    parameter int                SECTOR_BYTES = 65536,
    parameter int                BYTES_W      = 32,
    localparam int               SECT_W       = $clog2(SECTORS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               done,
    output logic [1:0]         vendor,
    output logic               dev_known,
    output logic [SECT_W-1:0]  sector_count,
    output logic [BYTES_W-1:0] bank_bytes,
    output logic [ADDR_W-1:0]  flash_addr,
    output logic [DATA_W-1:0]  flash_wdata,
    input  logic [DATA_W-1:0]  flash_rdata,
    output logic               flash_ce_n,
    output logic               flash_we_n,
    output logic               flash_oe_n
);
    logic              req, req_wr, ack, fin;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, rdata, rst_cmd;
    logic [7:0]        mfr_q, amfr_q;
    logic [DATA_W-1:0] dev_q, adev_q;
    logic [1:0]        d_vendor;
    logic              d_known;
    logic [SECT_W-1:0] d_sectors;
    logic [BYTES_W-1:0] d_bytes;

    nor_probe_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CLKS(WAIT_CLKS),
        .BASE_ADDR(BASE_ADDR), .ALIAS_OFS(ALIAS_OFS), .DEV_ID(DEV_ID),
        .MFR_A(MFR_A), .MFR_B(MFR_B)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ack(ack), .rdata(rdata),
        .rst_cmd(rst_cmd), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .fin(fin), .done_q(done),
        .mfr_q(mfr_q), .dev_q(dev_q), .amfr_q(amfr_q), .adev_q(adev_q)
    );

    nor_bus_cycle #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CLKS(PULSE_CLKS)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .bus_addr(flash_addr), .bus_wdata(flash_wdata), .bus_rdata(flash_rdata),
        .ce_n(flash_ce_n), .we_n(flash_we_n), .oe_n(flash_oe_n)
    );

    nor_id_decode #(
        .DATA_W(DATA_W), .DEV_ID(DEV_ID), .MFR_A(MFR_A), .MFR_B(MFR_B),
        .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES), .SECT_W(SECT_W),
        .BYTES_W(BYTES_W)
    ) u_dec (
        .mfr_q(mfr_q), .dev_q(dev_q), .amfr_q(amfr_q), .adev_q(adev_q),
        .vendor(d_vendor), .known(d_known), .sectors(d_sectors),
        .bytes(d_bytes), .rst_cmd(rst_cmd)
    );

    // Publish results on the same edge that raises done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vendor       <= '0;
            dev_known    <= 1'b0;
            sector_count <= '0;
            bank_bytes   <= '0;
        end else if (fin) begin
            vendor       <= d_vendor;
            dev_known    <= d_known;
            sector_count <= d_sectors;
            bank_bytes   <= d_bytes;
        end
    end

endmodule

// File: rtl/nor_id_probe_chk.sv
// Assertion checker for nor_id_probe, attached with bind below.
// Watches the flash strobes and the result outputs only.
module nor_id_probe_chk #(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 16,
    parameter int SECT_W  = 8,
    parameter int BYTES_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic [1:0]         vendor,
    input logic               dev_known,
    input logic [SECT_W-1:0]  sector_count,
    input logic [BYTES_W-1:0] bank_bytes,
    input logic [ADDR_W-1:0]  flash_addr,
    input logic [DATA_W-1:0]  flash_wdata,
    input logic               flash_ce_n,
    input logic               flash_we_n,
    input logic               flash_oe_n
);
    // R3: never write and read strobes together
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n));

    // R3: a strobe only inside chip enable
    p_strobe_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n || !flash_oe_n) |-> !flash_ce_n);

    // R3: address and data set up one clock before the strobe
    p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_ce_n) |-> ($stable(flash_addr) && $stable(flash_wdata)));

    // R3: address and data held into the clock after the strobe
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_ce_n) |-> ($stable(flash_addr) && $stable(flash_wdata)));

    // R3: address steady while strobing
    p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_ce_n && $past(!flash_ce_n)) |-> $stable(flash_addr));

    // R2: only known command bytes are written
    p_cmd_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_we_n) |-> (flash_wdata[7:0] == 8'hAA || flash_wdata[7:0] == 8'h55 ||
                               flash_wdata[7:0] == 8'h90 || flash_wdata[7:0] == 8'hF0 ||
                               flash_wdata[7:0] == 8'hFF));

    // R10: done lasts one clock
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: results only change with done
    p_results_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({vendor, dev_known, sector_count, bank_bytes}));

    // R7: an absent bank reports no size
    p_absent_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_known |-> (sector_count == '0 && bank_bytes == '0));

    // R5: a known device implies a known vendor
    p_known_vendor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_known |-> (vendor != 2'd0));

endmodule

bind nor_id_probe nor_id_probe_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .BYTES_W(BYTES_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .vendor(vendor),
    .dev_known(dev_known), .sector_count(sector_count), .bank_bytes(bank_bytes),
    .flash_addr(flash_addr), .flash_wdata(flash_wdata),
    .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
);

// File: tb/nor_id_probe_tb.sv
// Self-checking bench: behavioural flash model, bus monitor, a table of
// probe scenarios, then directed reset and busy-start tests.
module nor_id_probe_tb;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int PULSE  = 3;
    localparam int WAITC  = 20;
    localparam logic [ADDR_W-1:0] ALIAS = 24'h400000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, dev_known, ce_n, we_n, oe_n;
    logic [1:0] vendor;
    logic [7:0] sector_count;
    logic [31:0] bank_bytes;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, rdata;

    always #5 clk = ~clk;

    nor_id_probe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CLKS(PULSE),
                   .WAIT_CLKS(WAITC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .vendor(vendor),
        .dev_known(dev_known), .sector_count(sector_count), .bank_bytes(bank_bytes),
        .flash_addr(addr), .flash_wdata(wdata), .flash_rdata(rdata),
        .flash_ce_n(ce_n), .flash_we_n(we_n), .flash_oe_n(oe_n));

    // Flash model configuration and state
    logic [15:0] m_mfr, m_dev;
    logic        m_mirror;
    logic        id_mode;
    logic [ADDR_W-1:0] eff;

    // Read data from the model: chip 0 in identifier or array mode, chip 1 array.
    always_comb begin
        eff = m_mirror ? (addr & ~ALIAS) : addr;
        if ((eff & ALIAS) != '0) rdata = 16'hFFFF;
        else if (id_mode)        rdata = eff[0] ? m_dev : m_mfr;
        else                     rdata = 16'hFFFF;
    end

    // Monitor state
    int pass_n = 0, total_n = 0, cyc = 0;
    int n_wr, n_rd, t_err, w_err, done_cnt, gap, last_we_cyc, low_len;
    logic [ADDR_W-1:0] wr_a [8];
    logic [DATA_W-1:0] wr_d [8];
    logic              seen_rd;
    logic              p_we, p_oe;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_wdata;

    task automatic clear_mon();
        n_wr = 0; n_rd = 0; t_err = 0; w_err = 0; done_cnt = 0;
        gap = -1; seen_rd = 1'b0;
    endtask

    // Sample bus away from the clock edge: log cycles, measure widths.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (done) done_cnt = done_cnt + 1;
            if ((!we_n || !oe_n) && p_we && p_oe) begin
                if (addr !== p_addr || wdata !== p_wdata) t_err = t_err + 1;
                if (ce_n) t_err = t_err + 1;
                low_len = 1;
                if (!we_n) begin
                    if (n_wr < 8) begin wr_a[n_wr] = addr; wr_d[n_wr] = wdata; end
                    n_wr = n_wr + 1;
                    if (wdata[7:0] == 8'h90 && (addr & ALIAS) == '0) id_mode = 1'b1;
                    if (wdata[7:0] == 8'hF0 || wdata[7:0] == 8'hFF) id_mode = 1'b0;
                end else begin
                    n_rd = n_rd + 1;
                    if (!seen_rd) begin gap = cyc - last_we_cyc - 1; seen_rd = 1'b1; end
                end
            end else if (!we_n || !oe_n) begin
                low_len = low_len + 1;
                if (addr !== p_addr || wdata !== p_wdata || ce_n) t_err = t_err + 1;
            end else if (!p_we || !p_oe) begin
                if (low_len != PULSE) w_err = w_err + 1;
                if (addr !== p_addr || wdata !== p_wdata) t_err = t_err + 1;
            end
            if (!we_n) last_we_cyc = cyc;
        end
        p_we = we_n; p_oe = oe_n; p_addr = addr; p_wdata = wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total_n = total_n + 1;
        if (ok) pass_n = pass_n + 1;
        else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", pass_n, total_n);
        $finish;
    endtask

    // Watchdog
    initial begin
        #1_500_000;
        total_n = total_n + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Start one probe and wait for done; returns 0 on timeout.
    task automatic run_probe(output bit ok);
        int t;
        clear_mon();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        t = 0;
        while (!done && t < 3000) begin @(negedge clk); t = t + 1; end
        ok = done;
    endtask

    typedef struct packed {
        logic [15:0] mfr;
        logic [15:0] dev;
        logic        mirror;
        logic [1:0]  vend;
        logic        known;
        logic [3:0]  nwr;
        logic [3:0]  nrd;
        logic [7:0]  exit_cmd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0001, 16'h0093, 1'b0, 2'd1, 1'b1, 4'd4, 4'd4, 8'hF0},
        '{16'h0089, 16'h0093, 1'b0, 2'd2, 1'b1, 4'd4, 4'd4, 8'hFF},
        '{16'h0001, 16'h1234, 1'b0, 2'd1, 1'b0, 4'd4, 4'd2, 8'hF0},
        '{16'h0042, 16'h0093, 1'b0, 2'd0, 1'b0, 4'd3, 4'd1, 8'h00},
        '{16'h0001, 16'h0093, 1'b1, 2'd1, 1'b0, 4'd4, 4'd4, 8'hF0},
        '{16'hAB01, 16'h0093, 1'b0, 2'd1, 1'b1, 4'd4, 4'd4, 8'hF0},
        '{16'h0089, 16'h0093, 1'b1, 2'd2, 1'b0, 4'd4, 4'd4, 8'hFF},
        '{16'h0001, 16'h2293, 1'b0, 2'd1, 1'b0, 4'd4, 4'd2, 8'hF0}
    };

    initial begin
        bit ok;
        vec_t v;
        m_mfr = 16'h0001; m_dev = 16'h0093; m_mirror = 1'b0; id_mode = 1'b0;
        p_we = 1'b1; p_oe = 1'b1; p_addr = '0; p_wdata = '0;
        last_we_cyc = 0; low_len = 0;
        clear_mon();
        repeat (4) @(negedge clk);
        // R1: reset state
        check(done == 0 && vendor == 0 && dev_known == 0 && sector_count == 0 &&
              bank_bytes == 0, "R1", "reset results",
              {done, vendor, dev_known, sector_count, bank_bytes}, 0);
        check(ce_n && we_n && oe_n, "R1", "reset strobes", {ce_n, we_n, oe_n}, 3'b111);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            m_mfr = v.mfr; m_dev = v.dev; m_mirror = v.mirror; id_mode = 1'b0;
            run_probe(ok);
            check(ok, "R10", $sformatf("v%0d done seen", i), ok, 1);
            check(vendor == v.vend, "R5", $sformatf("v%0d vendor", i), vendor, v.vend);
            check(dev_known == v.known, v.mirror ? "R8" : "R6",
                  $sformatf("v%0d dev_known", i), dev_known, v.known);
            check(sector_count == (v.known ? 8'd128 : 8'd0) &&
                  bank_bytes == (v.known ? 32'h0080_0000 : 32'd0),
                  v.known ? "R6" : "R7", $sformatf("v%0d size", i),
                  {sector_count, bank_bytes}, v.known ? {8'd128, 32'h0080_0000} : 40'd0);
            @(negedge clk);
            check(!done, "R10", $sformatf("v%0d done width", i), done, 0);
            check(n_rd == int'(v.nrd), "R7", $sformatf("v%0d read count", i), n_rd, v.nrd);
            check(n_wr == int'(v.nwr), "R9", $sformatf("v%0d write count", i), n_wr, v.nwr);
            check(wr_a[0] == 24'h555 && wr_d[0] == 16'h00AA &&
                  wr_a[1] == 24'h2AA && wr_d[1] == 16'h0055 &&
                  wr_a[2] == 24'h555 && wr_d[2] == 16'h0090, "R2",
                  $sformatf("v%0d command sequence", i),
                  {wr_a[2], wr_d[2]}, {24'h555, 16'h0090});
            if (v.nwr == 4'd4)
                check(wr_a[3] == 24'h0 && wr_d[3] == {8'h00, v.exit_cmd}, "R9",
                      $sformatf("v%0d exit command", i), {wr_a[3], wr_d[3]},
                      {24'h0, 8'h00, v.exit_cmd});
            check(t_err == 0 && w_err == 0, "R3", $sformatf("v%0d bus timing", i),
                  {t_err[15:0], w_err[15:0]}, 0);
            check(gap >= WAITC, "R4", $sformatf("v%0d settle gap", i), gap, WAITC);
        end

        // R11: start while busy is ignored
        m_mfr = 16'h0001; m_dev = 16'h0093; m_mirror = 1'b0; id_mode = 1'b0;
        clear_mon();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (12) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (300) @(negedge clk);
        check(done_cnt == 1, "R11", "done pulses with busy starts", done_cnt, 1);
        check(n_wr == 4 && n_rd == 4, "R11", "bus cycles with busy starts",
              {n_wr[15:0], n_rd[15:0]}, {16'd4, 16'd4});
        check(dev_known && vendor == 2'd1 && sector_count == 8'd128, "R10",
              "results held after done", {vendor, dev_known, sector_count},
              {2'd1, 1'b1, 8'd128});
        finish_run();
    end

endmodule